// File: doc/BRIEF.md
# Synchronous FIFO Read Port with Chip Select

This block is the read-side controller of a single synchronous FIFO channel. It runs on the read clock and keeps a count of the words that the write side has committed. It generates the read address for an external storage array and loads the word returned by that array into a registered output. It also drives a flag that tells the consumer whether data can be read. The write side reports each committed word as a single-cycle pulse, already synchronised into the read clock domain. The block applies a fixed one-cycle visibility delay to that pulse.

Two read styles are selected at reset by a static mode input. In standard mode, a word is popped into the output register only when the consumer asks for it, and the flag is an empty indication. In fall-through mode, the head word is moved into the output register without being asked for, and the flag is an active-low ready indication.

An active-low chip select gates two things: pops, and the output-bus drive control. It never gates the flag logic or the fall-through load. An active-low output enable overrides the drive control at all times, and is the only control of the drive while reset is asserted.

Top module: `rdq_read_port`

## Requirements
- R1: Read enable and chip select are sampled only at rising clock edges. In standard mode, an edge with both low and at least one stored word puts the word at `mem_raddr_o` on `dout_o` after that edge, and advances `mem_raddr_o` by one (modulo the depth). With either input high, `dout_o` and `mem_raddr_o` hold.
- R2: A read request while no word is stored changes neither `dout_o` nor `mem_raddr_o`.
- R3: When chip select is high at a rising edge, `drive_o` is low after that edge, and no pop happens at that edge whatever the read enable level.
- R4: When chip select is low at a rising edge and output enable is low, `drive_o` is high after that edge.
- R5: In standard mode, `flag_o` is high when nothing is stored and low otherwise. A commit pulse sampled at edge N clears the flag after edge N+1. The flag sets again after the edge that pops the last stored word.
- R6: In fall-through mode, a word committed (edge N) into an empty FIFO appears on `dout_o` after edge N+2, and `flag_o` (ready, active low) falls after that same edge. This happens regardless of chip select and read enable.
- R7: In fall-through mode, an edge with read enable and chip select low while a word is held consumes that word. The next stored word replaces it after that edge. If no word is stored, `flag_o` goes high and `dout_o` holds.
- R8: In fall-through mode, chip select high with read enable low does not consume the held word. Chip select low with read enable high enables the drive and exposes the held word without consuming it.
- R9: Chip select has no effect on when `flag_o` changes.
- R10: `drive_o` is low whenever output enable is high. While reset is asserted, `drive_o` equals the inverse of output enable. After reset is released, `drive_o` stays high until the first rising edge.
- R11: After reset, `dout_o` is 0, `mem_raddr_o` is 0 and `flag_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fwft_i | input | 1 | Mode: 0 standard, 1 fall-through; static outside reset |
| ren_ni | input | 1 | Read enable, active low |
| rcs_ni | input | 1 | Read chip select, active low |
| oe_ni | input | 1 | Output enable, active low |
| commit_i | input | 1 | One-cycle pulse per word committed by the write side |
| mem_rdata_i | input | DATA_W | Word at `mem_raddr_o` from the storage array |
| mem_raddr_o | output | ADDR_W | Read address into the storage array |
| dout_o | output | DATA_W | Output data register |
| drive_o | output | 1 | Output bus drive enable (high = driven) |
| flag_o | output | 1 | Empty (standard) or ready-low (fall-through); high = nothing readable |

## Verification
Each result has a fixed latency, and the bench samples one time unit after the edge at which that result is due:

| Result | Due after |
|---|---|
| Pop, address step, drive change | The edge that samples the controls |
| Standard flag clear | The second edge, counting the edge that samples the commit pulse as the first |
| Fall-through load | The third edge, counting the same way |

The bench also checks that each result is not yet present one edge earlier. It sweeps every combination of read enable and chip select against held and empty states, in both modes. It pushes enough words to wrap the address, and predicts each output word from an arithmetic formula of its write index.

// File: rtl/rdq_pkg.sv
package rdq_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/rdq_occupancy.sv
module rdq_occupancy #(
  parameter int ADDR_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic commit_i,
  input  logic pop_i,
  output logic avail_o
);
  localparam int CNT_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic             pend_q;
  logic [CNT_W-1:0] cnt_q;

  // commit becomes visible one edge after it is sampled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= commit_i;
      cnt_q  <= cnt_q + CNT_W'(pend_q) - CNT_W'(pop_i);
    end
  end

  assign avail_o = (cnt_q != '0);

  assert_no_underflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> avail_o);
  assert_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  assert_fill_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !pop_i) |=> avail_o);
  assert_drain_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_W'(1) && pop_i && !pend_q) |=> !avail_o);
endmodule

// File: rtl/rdq_bus_ctrl.sv
module rdq_bus_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic oe_ni,
  output logic drive_o
);
  logic drv_q;

  // held driving through reset; chip select takes over at first edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drv_q <= 1'b1;
    else         drv_q <= !cs_ni;
  end

  assign drive_o = drv_q && !oe_ni;

  assert_cs_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !drv_q);
  assert_cs_on_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_ni |=> drv_q);
endmodule

// File: rtl/rdq_out_stage.sv
module rdq_out_stage #(
  parameter int DATA_W = 10,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  rdq_pkg::rd_mode_e mode_i,
  input  logic              ren_ni,
  input  logic              cs_ni,
  input  logic              avail_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_raddr_o,
  output logic              pop_o,
  output logic [DATA_W-1:0] dout_o,
  output logic              ready_n_o
);
  import rdq_pkg::*;

  logic [ADDR_W-1:0] ptr_q;
  logic [DATA_W-1:0] dout_q;
  logic              valid_q;
  logic              req;
  logic              fire;

  assign req  = !ren_ni && !cs_ni;
  assign fire = req && valid_q;

  always_comb begin
    if (mode_i == MODE_FWFT) pop_o = avail_i && (!valid_q || fire);
    else                     pop_o = avail_i && req;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      dout_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (pop_o) begin
        ptr_q  <= ptr_q + 1'b1;
        dout_q <= mem_rdata_i;
      end
      if (mode_i == MODE_FWFT) begin
        if (pop_o)     valid_q <= 1'b1;
        else if (fire) valid_q <= 1'b0;
      end else begin
        valid_q <= 1'b0;
      end
    end
  end

  assign mem_raddr_o = ptr_q;
  assign dout_o      = dout_q;
  assign ready_n_o   = !valid_q;

  assert_std_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_STD && (ren_ni || cs_ni)) |=> ($stable(dout_q) && $stable(ptr_q)));
  assert_cs_blocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_FWFT && cs_ni && valid_q) |=> (valid_q && $stable(dout_q)));
  assert_fall_through_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_FWFT && !valid_q && avail_i) |=> valid_q);
  assert_peek_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_FWFT && ren_ni && valid_q) |=> (valid_q && $stable(ptr_q)));
endmodule

// File: rtl/rdq_read_port.sv
module rdq_read_port #(
  parameter int DATA_W = 10,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fwft_i,
  input  logic              ren_ni,
  input  logic              rcs_ni,
  input  logic              oe_ni,
  input  logic              commit_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_raddr_o,
  output logic [DATA_W-1:0] dout_o,
  output logic              drive_o,
  output logic              flag_o
);
  import rdq_pkg::*;

  rd_mode_e mode;
  logic     avail;
  logic     pop;
  logic     ready_n;

  assign mode = rd_mode_e'(fwft_i);

  rdq_occupancy #(.ADDR_W(ADDR_W)) i_occ (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit_i),
    .pop_i    (pop),
    .avail_o  (avail)
  );

  rdq_out_stage #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .ren_ni      (ren_ni),
    .cs_ni       (rcs_ni),
    .avail_i     (avail),
    .mem_rdata_i (mem_rdata_i),
    .mem_raddr_o (mem_raddr_o),
    .pop_o       (pop),
    .dout_o      (dout_o),
    .ready_n_o   (ready_n)
  );

  rdq_bus_ctrl i_bus (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_ni   (rcs_ni),
    .oe_ni   (oe_ni),
    .drive_o (drive_o)
  );

  assign flag_o = (mode == MODE_FWFT) ? ready_n : !avail;

  assert_std_cs_no_move_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_STD && rcs_ni) |=> $stable(mem_raddr_o));
endmodule

// File: tb/test_rdq_read_port.sv
module test_rdq_read_port;
  localparam int DW = 10;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          fwft = 1'b0;
  logic          ren_n = 1'b1;
  logic          cs_n = 1'b1;
  logic          oe_n = 1'b0;
  logic          commit = 1'b0;
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] raddr;
  logic [DW-1:0] rdata;
  logic [DW-1:0] dout;
  logic          drive;
  logic          flag;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int wr_idx = 0;
  int rd_idx = 0;

  always #2.5 clk = ~clk;

  assign rdata = mem[raddr];

  rdq_read_port #(.DATA_W(DW), .ADDR_W(AW)) i_rdq_read_port (
    .clk_i(clk), .rst_ni(rst_ni), .fwft_i(fwft), .ren_ni(ren_n), .rcs_ni(cs_n),
    .oe_ni(oe_n), .commit_i(commit), .mem_rdata_i(rdata), .mem_raddr_o(raddr),
    .dout_o(dout), .drive_o(drive), .flag_o(flag)
  );

  function automatic logic [DW-1:0] val(int i);
    return DW'((i * 37 + 5) % 1024);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic put_word();
    mem[wr_idx % DEPTH] = val(wr_idx);
    wr_idx++;
  endtask

  task automatic do_reset(logic mode);
    rst_ni = 1'b0;
    fwft = mode;
    commit = 1'b0;
    wr_idx = 0;
    rd_idx = 0;
    tick();
    tick();
    rst_ni = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    #1;
    // reset behaviour, standard mode
    tick();
    chk("R10 drive in reset", int'(drive), 1);
    oe_n = 1'b1; #0.5;
    chk("R10 oe high", int'(drive), 0);
    oe_n = 1'b0; #0.5;
    chk("R11 flag", int'(flag), 1);
    chk("R11 dout", int'(dout), 0);
    chk("R11 addr", int'(raddr), 0);
    do_reset(1'b0);
    #0.5;
    chk("R10 driven until first edge", int'(drive), 1);
    tick();
    chk("R3 cs high drive off", int'(drive), 0);

    // empty read attempt
    ren_n = 1'b0; cs_n = 1'b0;
    tick();
    chk("R2 empty read dout", int'(dout), 0);
    chk("R2 empty read addr", int'(raddr), 0);
    chk("R4 drive on", int'(drive), 1);

    // commit with chip select high; flag timing unaffected
    ren_n = 1'b1; cs_n = 1'b1;
    put_word(); commit = 1'b1;
    tick();
    commit = 1'b0;
    chk("R5 R9 flag still set", int'(flag), 1);
    tick();
    chk("R5 R9 flag cleared", int'(flag), 0);

    // sweep non-read control combinations
    for (int c = 0; c < 3; c++) begin
      ren_n = (c == 1) ? 1'b0 : 1'b1;
      cs_n  = (c == 2) ? 1'b0 : 1'b1;
      tick();
      chk("R1 R3 no pop addr", int'(raddr), 0);
      chk("R1 no pop dout", int'(dout), 0);
      chk("R1 flag held", int'(flag), 0);
      chk("R3 R4 drive", int'(drive), int'(!cs_n));
    end
    ren_n = 1'b0; cs_n = 1'b0;
    tick();
    chk("R1 pop dout", int'(dout), int'(val(rd_idx)));
    rd_idx++;
    chk("R1 pop addr", int'(raddr), 1);
    chk("R5 flag after last", int'(flag), 1);

    // bursts that wrap the address
    for (int r = 0; r < 3; r++) begin
      ren_n = 1'b1;
      for (int k = 0; k < 7; k++) begin
        put_word(); commit = 1'b1;
        tick();
      end
      commit = 1'b0;
      tick();
      chk("R5 flag after burst", int'(flag), 0);
      ren_n = 1'b0;
      for (int k = 0; k < 7; k++) begin
        tick();
        chk("R1 burst dout", int'(dout), int'(val(rd_idx)));
        rd_idx++;
        chk("R1 burst addr", int'(raddr), rd_idx % DEPTH);
        chk("R5 burst flag", int'(flag), (k == 6) ? 1 : 0);
      end
      tick();
      chk("R2 empty dout", int'(dout), int'(val(rd_idx - 1)));
      chk("R2 empty addr", int'(raddr), rd_idx % DEPTH);
    end

    // fall-through mode
    ren_n = 1'b0; cs_n = 1'b1;
    do_reset(1'b1);
    put_word(); commit = 1'b1;
    tick();
    commit = 1'b0;
    chk("R6 flag edge1", int'(flag), 1);
    tick();
    chk("R6 flag edge2", int'(flag), 1);
    chk("R6 dout edge2", int'(dout), 0);
    tick();
    chk("R6 R9 flag edge3", int'(flag), 0);
    chk("R6 dout edge3", int'(dout), int'(val(0)));
    chk("R3 drive off", int'(drive), 0);
    ren_n = 1'b1; cs_n = 1'b0;
    tick();
    chk("R8 peek drive", int'(drive), 1);
    chk("R8 peek dout", int'(dout), int'(val(0)));
    chk("R8 peek addr", int'(raddr), 1);
    for (int k = 0; k < 2; k++) begin
      put_word(); commit = 1'b1;
      tick();
    end
    commit = 1'b0;
    tick();
    tick();
    chk("R8 held dout", int'(dout), int'(val(0)));
    ren_n = 1'b0; cs_n = 1'b1;
    tick();
    chk("R8 cs high no consume", int'(dout), int'(val(0)));
    chk("R8 cs high addr", int'(raddr), 1);
    cs_n = 1'b0;
    tick();
    chk("R7 next word", int'(dout), int'(val(1)));
    chk("R7 flag", int'(flag), 0);
    tick();
    chk("R7 third word", int'(dout), int'(val(2)));
    chk("R7 flag", int'(flag), 0);
    tick();
    chk("R7 drained flag", int'(flag), 1);
    chk("R7 drained dout", int'(dout), int'(val(2)));
    chk("R7 drained addr", int'(raddr), 3);
    ren_n = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule